// File: doc/BRIEF.md
# Keyed Watchdog Timer with Early Warning

This block is a system watchdog. Once armed, it advances a counter on each cycle where the slow reference tick (nominally 1 kHz) is high. If software does not restart the counter in time, the block raises a one-cycle reset request. A single-cycle early-warning pulse comes out some time before that, so that software can take a last action through a non-maskable interrupt.

Arming and disarming are guarded against stray writes. Software first writes a 16-bit key, then applies a separate arm or disarm strobe. The arm key is 0xEABE and the disarm key is 0xDEAD. Any strobe consumes the stored key, so each attempt needs a fresh key write.

Counting freezes in two cases:
- a debug halt is asserted while the pause option is configured;
- the reference tick stops, for example in deep sleep. Counting then just stops, with no error.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the watchdog is disabled and both outputs are low. Ticks alone never produce a warning or a reset request.
- R2: Writing key 0xEABE and then applying the arm strobe starts counting from zero. On the tick that brings the count to TIMEOUT_TICKS (default 2048), `resetReq` is high for exactly one cycle. It is visible in the cycle after the edge that samples that tick.
- R3: On the tick that brings the count to WARN_TICKS (default 1792), `warnPulse` is high for exactly one cycle. This happens once per period and never together with `resetReq`.
- R4: An arm or disarm strobe is ignored unless the last key written matches that strobe. An arm strobe after key 0xDEAD does nothing, and neither does an arm strobe with no key.
- R5: Any arm or disarm strobe clears the stored key, whether it succeeds or not. A following strobe needs a new key write.
- R6: Writing key 0xDEAD and then applying the disarm strobe stops counting and clears the count to zero. A later arm starts a full period again.
- R7: A restart strobe while armed reloads the count to zero and re-arms the warning. It wins over a tick in the same cycle. While disarmed it has no effect.
- R8: With the pause option set (it takes effect one cycle after it is written), ticks are ignored while `haltIn` is high. With the option clear, `haltIn` has no effect.
- R9: Cycles with `tickIn` low leave the count unchanged.
- R10: After a reset request the watchdog is disarmed. Further ticks produce no warning and no reset request until it is armed again with the key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| keyWe | input | 1 | Write strobe for the key register |
| keyData | input | 16 | Key value written when `keyWe` is high |
| armStrobe | input | 1 | Request to arm; honoured only after key 0xEABE |
| disarmStrobe | input | 1 | Request to disarm; honoured only after key 0xDEAD |
| kickStrobe | input | 1 | Restart request; reloads the count while armed |
| pauseWe | input | 1 | Write strobe for the debug-pause option |
| pauseData | input | 1 | New value of the debug-pause option |
| tickIn | input | 1 | Reference tick, one cycle high per count step |
| haltIn | input | 1 | Debug-halt indication |
| warnPulse | output | 1 | Single-cycle early-warning pulse |
| resetReq | output | 1 | Single-cycle reset request on expiry |

## Verification
Both outputs are registered. A warning or reset request caused by a tick sampled at one rising edge is therefore visible from that edge until the next one. The bench drives each cycle's inputs at the falling edge. It reads the outputs at the following falling edge and compares them with its model's prediction for that same cycle.

Arm, disarm, key, restart and pause writes act at the edge that samples them, except the pause option, which governs counting only from the next cycle on. Directed checks count exact tick numbers (1791 against 1792, 2047 against 2048) after each such write to pin down those latencies.

// File: rtl/kw_pkg.sv
package kw_pkg;
  // Command from control to counter datapath
  typedef struct packed {
    logic clear;  // reload count to zero this cycle
    logic step;   // advance count by one this cycle
  } kw_cmd_t;
endpackage

// File: rtl/kw_ctrl.sv
module kw_ctrl
  import kw_pkg::*;
#(
  parameter int KEY_W = 16,
  parameter logic [KEY_W-1:0] ARM_KEY = 16'hEABE,
  parameter logic [KEY_W-1:0] DISARM_KEY = 16'hDEAD
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             keyWe,
  input  logic [KEY_W-1:0] keyData,
  input  logic             armStrobe,
  input  logic             disarmStrobe,
  input  logic             kickStrobe,
  input  logic             pauseWe,
  input  logic             pauseData,
  input  logic             tickIn,
  input  logic             haltIn,
  input  logic             expireNow,
  output kw_cmd_t          cmd,
  output logic             enabledQ,
  output logic             pauseQ
);
  logic [KEY_W-1:0] keyQ;
  logic armOk, disarmOk, frozen;

  // R4: a strobe counts only when the stored key matches it
  assign armOk    = armStrobe && (keyQ == ARM_KEY);
  assign disarmOk = disarmStrobe && (keyQ == DISARM_KEY);
  // R8: freeze only when the pause option is set and halt is high
  assign frozen   = pauseQ && haltIn;

  always_comb begin
    cmd = '0;
    // R6, R7: a disarm clears the count; a restart clears it only while armed
    cmd.clear = disarmOk || (kickStrobe && enabledQ);
    // R9: advance only on a tick
    cmd.step  = enabledQ && tickIn && !frozen;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      keyQ     <= '0;
      enabledQ <= 1'b0;  // R1
      pauseQ   <= 1'b0;
    end else begin
      // R5: any strobe attempt consumes the key
      if (armStrobe || disarmStrobe) keyQ <= '0;
      else if (keyWe)                keyQ <= keyData;
      // R10: expiry disarms; a disarm wins over an arm
      if (disarmOk || expireNow) enabledQ <= 1'b0;
      else if (armOk)            enabledQ <= 1'b1;
      if (pauseWe) pauseQ <= pauseData;
    end
  end
endmodule

// File: rtl/kw_count.sv
module kw_count
  import kw_pkg::*;
#(
  parameter int TIMEOUT_TICKS = 2048,
  parameter int WARN_TICKS = 1792,
  localparam int CNT_W = $clog2(TIMEOUT_TICKS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  kw_cmd_t          cmd,
  output logic             expireNow,
  output logic             warnPulse,
  output logic             resetReq,
  output logic [CNT_W-1:0] cntQ
);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(TIMEOUT_TICKS - 1);
  localparam logic [CNT_W-1:0] WARN_CNT = CNT_W'(WARN_TICKS - 1);

  logic live, warnNow;
  assign live      = cmd.step && !cmd.clear;  // R7: a restart wins over a tick
  assign expireNow = live && (cntQ == LAST_CNT);
  assign warnNow   = live && (cntQ == WARN_CNT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ      <= '0;
      warnPulse <= 1'b0;
      resetReq  <= 1'b0;
    end else begin
      warnPulse <= warnNow;    // R3
      resetReq  <= expireNow;  // R2
      if (cmd.clear || expireNow) cntQ <= '0;
      else if (cmd.step)          cntQ <= cntQ + 1'b1;
    end
  end
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import kw_pkg::*;
#(
  parameter int KEY_W = 16,
  parameter logic [KEY_W-1:0] ARM_KEY = 16'hEABE,
  parameter logic [KEY_W-1:0] DISARM_KEY = 16'hDEAD,
  parameter int TIMEOUT_TICKS = 2048,
  parameter int WARN_TICKS = 1792,
  localparam int CNT_W = $clog2(TIMEOUT_TICKS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             keyWe,
  input  logic [KEY_W-1:0] keyData,
  input  logic             armStrobe,
  input  logic             disarmStrobe,
  input  logic             kickStrobe,
  input  logic             pauseWe,
  input  logic             pauseData,
  input  logic             tickIn,
  input  logic             haltIn,
  output logic             warnPulse,
  output logic             resetReq
);
  kw_cmd_t cmd;
  logic expireNow, enabledQ, pauseQ;
  logic [CNT_W-1:0] cntQ;

  kw_ctrl #(.KEY_W(KEY_W), .ARM_KEY(ARM_KEY), .DISARM_KEY(DISARM_KEY)) ctrl (
    .clk(clk), .rstN(rstN), .keyWe(keyWe), .keyData(keyData),
    .armStrobe(armStrobe), .disarmStrobe(disarmStrobe), .kickStrobe(kickStrobe),
    .pauseWe(pauseWe), .pauseData(pauseData), .tickIn(tickIn), .haltIn(haltIn),
    .expireNow(expireNow), .cmd(cmd), .enabledQ(enabledQ), .pauseQ(pauseQ)
  );

  kw_count #(.TIMEOUT_TICKS(TIMEOUT_TICKS), .WARN_TICKS(WARN_TICKS)) count (
    .clk(clk), .rstN(rstN), .cmd(cmd), .expireNow(expireNow),
    .warnPulse(warnPulse), .resetReq(resetReq), .cntQ(cntQ)
  );
endmodule

// File: rtl/kw_checker.sv
module kw_checker #(
  parameter int CNT_W = 11,
  parameter int TIMEOUT_TICKS = 2048
) (
  input logic             clk,
  input logic             rstN,
  input logic             tickIn,
  input logic             haltIn,
  input logic             kickStrobe,
  input logic             disarmStrobe,
  input logic             warnPulse,
  input logic             resetReq,
  input logic             enabledQ,
  input logic             pauseQ,
  input logic [CNT_W-1:0] cntQ
);
  // R2
  reset_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |=> !resetReq);
  // R3
  warn_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    warnPulse |=> !warnPulse);
  // R3
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(warnPulse && resetReq));
  // R10
  expire_disarms_chk: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> !enabledQ);
  // R6
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enabledQ |-> (cntQ == '0));
  // R8
  pause_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pauseQ && haltIn && !kickStrobe && !disarmStrobe) |=> $stable(cntQ));
  // R9
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!tickIn && !kickStrobe && !disarmStrobe) |=> $stable(cntQ));
  // R2
  count_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    cntQ <= CNT_W'(TIMEOUT_TICKS - 1));
endmodule

bind keyed_watchdog kw_checker #(.CNT_W(CNT_W), .TIMEOUT_TICKS(TIMEOUT_TICKS)) chk (
  .clk(clk), .rstN(rstN), .tickIn(tickIn), .haltIn(haltIn),
  .kickStrobe(kickStrobe), .disarmStrobe(disarmStrobe),
  .warnPulse(warnPulse), .resetReq(resetReq),
  .enabledQ(enabledQ), .pauseQ(pauseQ), .cntQ(cntQ)
);

// File: tb/keyed_watchdog_test.sv
`timescale 1ns/1ps
module keyed_watchdog_test;
  localparam int TO = 2048;
  localparam int WN = 1792;
  localparam logic [15:0] KARM = 16'hEABE;
  localparam logic [15:0] KDIS = 16'hDEAD;

  typedef struct {
    logic kw; logic [15:0] kd; logic arm; logic dis; logic kick;
    logic pw; logic pd; logic tick; logic halt;
  } op_t;

  logic clk = 0, rstN = 0;
  logic keyWe = 0, armStrobe = 0, disarmStrobe = 0, kickStrobe = 0;
  logic pauseWe = 0, pauseData = 0, tickIn = 0, haltIn = 0;
  logic [15:0] keyData = '0;
  logic warnPulse, resetReq;

  int errors = 0, checks = 0;
  bit done = 0;
  // bench model state
  logic mEn = 0, mPause = 0;
  logic [15:0] mKey = '0;
  int mCnt = 0;
  logic expW = 0, expR = 0;
  int seenW = 0, seenR = 0;

  keyed_watchdog uut (
    .clk(clk), .rstN(rstN), .keyWe(keyWe), .keyData(keyData),
    .armStrobe(armStrobe), .disarmStrobe(disarmStrobe), .kickStrobe(kickStrobe),
    .pauseWe(pauseWe), .pauseData(pauseData), .tickIn(tickIn), .haltIn(haltIn),
    .warnPulse(warnPulse), .resetReq(resetReq)
  );

  always #5 clk = ~clk;

  function automatic op_t idle();
    op_t o;
    o.kw = 0; o.kd = '0; o.arm = 0; o.dis = 0; o.kick = 0;
    o.pw = 0; o.pd = 0; o.tick = 0; o.halt = 0;
    return o;
  endfunction

  function automatic bit counts(op_t o, logic en, logic pz);
    return en && o.tick && !(pz && o.halt);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // One cycle: drive at negedge, model update, compare at next negedge
  task automatic step(input op_t o);
    bit armOk, disOk, clr, stp;
    keyWe = o.kw; keyData = o.kd; armStrobe = o.arm; disarmStrobe = o.dis;
    kickStrobe = o.kick; pauseWe = o.pw; pauseData = o.pd;
    tickIn = o.tick; haltIn = o.halt;
    armOk = o.arm && mKey == KARM;
    disOk = o.dis && mKey == KDIS;
    clr = disOk || (o.kick && mEn);
    stp = counts(o, mEn, mPause);
    expW = stp && !clr && mCnt == WN - 1;
    expR = stp && !clr && mCnt == TO - 1;
    if (clr || expR) mCnt = 0; else if (stp) mCnt = mCnt + 1;
    if (disOk || expR) mEn = 0; else if (armOk) mEn = 1;
    if (o.arm || o.dis) mKey = '0; else if (o.kw) mKey = o.kd;
    if (o.pw) mPause = o.pd;
    @(posedge clk);
    @(negedge clk);
    if (warnPulse) seenW++;
    if (resetReq) seenR++;
    check(warnPulse == expW, "R3 warn timing", int'(warnPulse), int'(expW));
    check(resetReq == expR, "R2 reset timing", int'(resetReq), int'(expR));
  endtask

  task automatic writeKey(input logic [15:0] k);
    op_t o = idle(); o.kw = 1; o.kd = k; step(o);
  endtask
  task automatic doArm();    op_t o = idle(); o.arm = 1; step(o); endtask
  task automatic doDisarm(); op_t o = idle(); o.dis = 1; step(o); endtask
  task automatic doKick(input logic withTick);
    op_t o = idle(); o.kick = 1; o.tick = withTick; step(o);
  endtask
  task automatic setPause(input logic v);
    op_t o = idle(); o.pw = 1; o.pd = v; step(o);
  endtask
  task automatic ticks(input int n, input logic halt);
    for (int i = 0; i < n; i++) begin
      op_t o = idle(); o.tick = 1; o.halt = halt; step(o);
    end
  endtask
  task automatic quiet(input int n);
    for (int i = 0; i < n; i++) step(idle());
  endtask
  task automatic disarmAll();
    writeKey(KDIS); doDisarm();
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1: reset state and no activity without arming
    check(warnPulse == 0 && resetReq == 0, "R1 reset outputs", int'(warnPulse | resetReq), 0);
    seenW = 0; seenR = 0;
    ticks(TO + 50, 0);
    check(seenW == 0 && seenR == 0, "R1 idle after reset", seenW + seenR, 0);

    // R2, R3: arm, warning at 1792, reset at 2048
    writeKey(KARM); doArm();
    ticks(WN - 1, 0);
    check(warnPulse == 0, "R3 before warn", int'(warnPulse), 0);
    ticks(1, 0);
    check(warnPulse == 1, "R3 warn at 1792", int'(warnPulse), 1);
    ticks(TO - WN - 1, 0);
    check(resetReq == 0, "R2 before expiry", int'(resetReq), 0);
    ticks(1, 0);
    check(resetReq == 1, "R2 expiry at 2048", int'(resetReq), 1);
    // R10: disarmed after expiry
    seenW = 0; seenR = 0;
    ticks(TO + 10, 0);
    check(seenW == 0 && seenR == 0, "R10 idle after expiry", seenW + seenR, 0);

    // R4: no key, and wrong key
    doArm(); writeKey(KDIS); doArm();
    seenW = 0; seenR = 0;
    ticks(TO + 10, 0);
    check(seenR == 0, "R4 arm without matching key", seenR, 0);

    // R5: failed disarm consumes the arm key
    writeKey(KARM); doDisarm(); doArm();
    seenW = 0; seenR = 0;
    ticks(TO + 10, 0);
    check(seenR == 0, "R5 key consumed by strobe", seenR, 0);

    // R6: disarm clears the count
    writeKey(KARM); doArm();
    ticks(1000, 0);
    disarmAll();
    seenW = 0;
    ticks(1000, 0);
    check(seenW == 0, "R6 stopped after disarm", seenW, 0);
    writeKey(KARM); doArm();
    ticks(WN - 1, 0);
    check(warnPulse == 0, "R6 count restarted at zero", int'(warnPulse), 0);
    ticks(1, 0);
    check(warnPulse == 1, "R6 full period after rearm", int'(warnPulse), 1);
    disarmAll();

    // R7: restart reloads and re-arms warning; wins over a tick
    writeKey(KARM); doArm();
    ticks(1700, 0);
    doKick(1);
    ticks(WN - 1, 0);
    check(warnPulse == 0, "R7 kick reloads count", int'(warnPulse), 0);
    ticks(1, 0);
    check(warnPulse == 1, "R7 warn re-armed", int'(warnPulse), 1);
    doKick(0);
    ticks(WN, 0);
    check(warnPulse == 1, "R7 second warn after kick", int'(warnPulse), 1);
    disarmAll();
    doKick(0);  // while disarmed: no effect
    seenR = 0;
    ticks(TO + 10, 0);
    check(seenR == 0, "R7 kick while disarmed", seenR, 0);

    // R8: pause option with halt freezes; halt alone does not
    setPause(1);
    writeKey(KARM); doArm();
    ticks(500, 1);
    ticks(WN - 1, 0);
    check(warnPulse == 0, "R8 frozen during halt", int'(warnPulse), 0);
    ticks(1, 0);
    check(warnPulse == 1, "R8 warn after halt", int'(warnPulse), 1);
    disarmAll();
    setPause(0);
    writeKey(KARM); doArm();
    ticks(WN, 1);
    check(warnPulse == 1, "R8 halt ignored when option clear", int'(warnPulse), 1);
    disarmAll();

    // R9: no tick, no count
    writeKey(KARM); doArm();
    ticks(WN - 1, 0);
    quiet(300);
    check(seenW >= 0 && warnPulse == 0, "R9 hold without tick", int'(warnPulse), 0);
    ticks(1, 0);
    check(warnPulse == 1, "R9 resumes on tick", int'(warnPulse), 1);
    disarmAll();

    // Random phase, compared every cycle against the model
    for (int i = 0; i < 40000; i++) begin
      op_t o = idle();
      int unsigned r = $urandom % 100;
      if (r < 3) begin
        int unsigned s = $urandom % 3;
        o.kw = 1;
        o.kd = (s == 0) ? KARM : (s == 1) ? KDIS : 16'($urandom);
      end else if (r < 6) o.arm = 1;
      else if (r < 7) o.dis = 1;
      if ($urandom % 400 == 0) o.kick = 1;
      if ($urandom % 50 == 0) begin o.pw = 1; o.pd = 1'($urandom); end
      o.tick = ($urandom % 4) != 0;
      o.halt = ($urandom % 5) == 0;
      step(o);
    end

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule